// File: doc/BRIEF.md
# Line Code Violation Performance Counter

This block gathers line performance statistics on the receive side of a T1 line interface. An upstream line decoder sends single-cycle pulses for bipolar violations and for runs of excessive zeros. The block merges them into one violation count. That count builds up silently in a live counter. At the end of each accounting interval it is copied into a holding register and the live counter starts again from zero. The live counter saturates at its all-ones value and never wraps.

The accounting interval comes from a tick counter on the system clock. It lasts one second, or about 42 ms when a control bit selects the short period. Each interval boundary sets a sticky status flag. Gated by an enable bit, that flag becomes an interrupt request, which tells the host that a fresh result is waiting. The host then has a whole interval to read the two bytes of the result. Both bytes always belong to the same snapshot.

When B8ZS decoding is enabled, the decoder marks the violations that belong to a substitution code word, and the block does not count them. Loss of receive synchronisation never stops the count.

Top module: `lcv_perf_counter`

## Requirements
- R1: After reset the result registers read 0x00, the control register reads 0x00 (one-second period, interrupt disabled, B8ZS off), the status flag reads 0 and `irq` is low.
- R2: The 16-bit result changes only at an interval boundary. At a boundary it takes the number of violation cycles seen in the interval just ended, and between boundaries it keeps that value.
- R3: The live count saturates at 0xFFFF and stays there until the next boundary. A saturated interval publishes 0xFFFF.
- R4: In the cycle of a boundary the live count loads 0, or 1 if a violation is present in that cycle. That violation belongs to the new interval.
- R5: With control bit 0 at 0 an interval lasts TICKS_PER_SEC clock cycles. With control bit 0 at 1 it lasts TICKS_PER_SEC*42/1000 cycles, rounded to the nearest integer.
- R6: A change of control bit 0 restarts the tick counter from zero. The first boundary under the new period comes one full new period later.
- R7: Status bit 0 (address 0x21) is set at every boundary and stays set until the host writes 1 to it. Writing 0 leaves it unchanged. A boundary in the same cycle as a clearing write wins, so the flag stays set.
- R8: `irq` equals status bit 0 ANDed with control bit 1 (address 0x20).
- R9: With control bit 2 (B8ZS enable) at 1, a bipolar violation pulse that comes with `b8zs_word` is not counted. An excessive-zero pulse is always counted. With control bit 2 at 0, `b8zs_word` has no effect.
- R10: A bipolar violation and an excessive-zero pulse in the same cycle add one to the count, not two.
- R11: `los_ind` has no effect on counting.
- R12: Address 0x23 reads the result high byte and 0x24 reads the low byte. 0x20 reads control bits [2:0] and 0x21 reads the status flag in bit 0, with all other bits 0. Any other address reads 0x00, and writes to it change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bpv_pulse | input | 1 | One-cycle bipolar violation event |
| exz_pulse | input | 1 | One-cycle excessive-zeros event |
| b8zs_word | input | 1 | Current violation belongs to a B8ZS substitution word |
| los_ind | input | 1 | Receive loss-of-synchronisation indicator (does not gate counting) |
| reg_addr | input | 8 | Host register address |
| reg_wr | input | 1 | Host write strobe |
| reg_wdata | input | 8 | Host write data |
| reg_rdata | output | 8 | Host read data, combinational from the address |
| irq | output | 1 | Boundary interrupt request |

## Verification
The live count is never visible at the ports. An error in it, such as a lost boundary-cycle event, a wrap instead of saturation, or a masked event that was still counted, shows up only in the two result bytes. That happens one cycle after the next boundary, up to a full interval later. An error in the tick counter shows as the status flag and `irq` rising in the wrong cycle, and a cycle-accurate model catches this at the first boundary. For these reasons the bench compares every port against that model on every cycle, and it also checks the directed patterns against literal expected totals.

// File: rtl/lcv_pkg.sv
package lcv_pkg;
  localparam int LCV_W = 16;
  localparam logic [LCV_W-1:0] LCV_MAX = {LCV_W{1'b1}};

  localparam logic [7:0] A_CTRL = 8'h20;
  localparam logic [7:0] A_STAT = 8'h21;
  localparam logic [7:0] A_HIGH = 8'h23;
  localparam logic [7:0] A_LOW  = 8'h24;

  typedef struct packed {
    logic b8zs_en;
    logic irq_en;
    logic short_per;
  } lcv_ctrl_t;

  // Ticks in the short period: ticks_per_sec * 42 / 1000, rounded.
  function automatic longint short_ticks(longint per_sec);
    return (per_sec * 42 + 500) / 1000;
  endfunction

  // Saturating increment of the live count.
  function automatic logic [LCV_W-1:0] sat_inc(logic [LCV_W-1:0] v, logic inc);
    if (v == LCV_MAX) return v;
    return v + LCV_W'(inc);
  endfunction

  // Merge of the two event types with optional substitution masking.
  function automatic logic qualify(logic bpv, logic exz, logic sub, logic mask_en);
    return (bpv & ~(mask_en & sub)) | exz;
  endfunction
endpackage

// File: rtl/lcv_tick_timer.sv
module lcv_tick_timer
  import lcv_pkg::*;
#(
  parameter int unsigned TICKS_PER_SEC = 125_000_000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic period_sel,
  output logic boundary
);
  localparam int unsigned LIM_LONG  = TICKS_PER_SEC;
  localparam int unsigned LIM_SHORT = int'(short_ticks(longint'(TICKS_PER_SEC)));
  localparam int CNT_W = $clog2(LIM_LONG + 1);

  logic [CNT_W-1:0] cnt;
  logic             sel_q;
  logic             sel_change;
  logic [CNT_W-1:0] last_tick;

  assign sel_change = (period_sel != sel_q);
  assign last_tick  = sel_q ? CNT_W'(LIM_SHORT - 1) : CNT_W'(LIM_LONG - 1);
  assign boundary   = !sel_change && (cnt == last_tick);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt   <= '0;
      sel_q <= 1'b0;
    end else begin
      sel_q <= period_sel;
      if (sel_change || boundary) cnt <= '0;
      else                        cnt <= cnt + 1'b1;
    end
  end

  p_restart_r6: assert property (@(posedge clk) disable iff (!rst_n)
    sel_change |=> (cnt == '0));
  p_advance_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (!sel_change && !boundary) |=> (cnt == $past(cnt) + 1'b1));
  p_wrap_r5: assert property (@(posedge clk) disable iff (!rst_n)
    boundary |=> (cnt == '0) && !boundary);
endmodule

// File: rtl/lcv_event_qual.sv
module lcv_event_qual
  import lcv_pkg::*;
(
  input  logic bpv,
  input  logic exz,
  input  logic sub_word,
  input  logic mask_en,
  output logic event_out
);
  assign event_out = qualify(bpv, exz, sub_word, mask_en);
endmodule

// File: rtl/lcv_count_core.sv
module lcv_count_core
  import lcv_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             boundary,
  input  logic             event_in,
  output logic [LCV_W-1:0] live_count,
  output logic [LCV_W-1:0] held_count
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      live_count <= '0;
      held_count <= '0;
    end else if (boundary) begin
      held_count <= live_count;
      live_count <= LCV_W'(event_in);
    end else begin
      live_count <= sat_inc(live_count, event_in);
    end
  end

  p_no_overflow_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (live_count == LCV_MAX && !boundary) |=> (live_count == LCV_MAX));
  p_hold_stable_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !boundary |=> $stable(held_count));
  p_publish_r2: assert property (@(posedge clk) disable iff (!rst_n)
    boundary |=> (held_count == $past(live_count)));
  p_boundary_load_r4: assert property (@(posedge clk) disable iff (!rst_n)
    boundary |=> (live_count == LCV_W'($past(event_in))));
endmodule

// File: rtl/lcv_host_regs.sv
module lcv_host_regs
  import lcv_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic [7:0]       addr,
  input  logic             wr,
  input  logic [7:0]       wdata,
  input  logic             boundary,
  input  logic [LCV_W-1:0] held_count,
  output lcv_ctrl_t        ctrl,
  output logic             flag,
  output logic [7:0]       rdata
);
  logic ctrl_wr;
  logic flag_clr;

  assign ctrl_wr  = wr && (addr == A_CTRL);
  assign flag_clr = wr && (addr == A_STAT) && wdata[0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl <= '0;
      flag <= 1'b0;
    end else begin
      if (ctrl_wr) ctrl <= lcv_ctrl_t'(wdata[2:0]);
      if (boundary)      flag <= 1'b1;
      else if (flag_clr) flag <= 1'b0;
    end
  end

  always_comb begin
    case (addr)
      A_CTRL:  rdata = {5'b0, ctrl};
      A_STAT:  rdata = {7'b0, flag};
      A_HIGH:  rdata = held_count[15:8];
      A_LOW:   rdata = held_count[7:0];
      default: rdata = 8'h00;
    endcase
  end

  p_flag_set_r7: assert property (@(posedge clk) disable iff (!rst_n)
    boundary |=> flag);
  p_flag_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (flag && !flag_clr) |=> flag);
  p_flag_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_clr && !boundary) |=> !flag);
endmodule

// File: rtl/lcv_perf_counter.sv
module lcv_perf_counter
  import lcv_pkg::*;
#(
  parameter int unsigned TICKS_PER_SEC = 125_000_000
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       bpv_pulse,
  input  logic       exz_pulse,
  input  logic       b8zs_word,
  input  logic       los_ind,
  input  logic [7:0] reg_addr,
  input  logic       reg_wr,
  input  logic [7:0] reg_wdata,
  output logic [7:0] reg_rdata,
  output logic       irq
);
  lcv_ctrl_t        ctrl;
  logic             boundary;
  logic             viol_event;
  logic             flag;
  logic [LCV_W-1:0] live_count;
  logic [LCV_W-1:0] held_count;

  lcv_tick_timer #(.TICKS_PER_SEC(TICKS_PER_SEC)) u_timer (
    .clk        (clk),
    .rst_n      (rst_n),
    .period_sel (ctrl.short_per),
    .boundary   (boundary)
  );

  lcv_event_qual u_qual (
    .bpv       (bpv_pulse),
    .exz       (exz_pulse),
    .sub_word  (b8zs_word),
    .mask_en   (ctrl.b8zs_en),
    .event_out (viol_event)
  );

  lcv_count_core u_core (
    .clk        (clk),
    .rst_n      (rst_n),
    .boundary   (boundary),
    .event_in   (viol_event),
    .live_count (live_count),
    .held_count (held_count)
  );

  lcv_host_regs u_regs (
    .clk        (clk),
    .rst_n      (rst_n),
    .addr       (reg_addr),
    .wr         (reg_wr),
    .wdata      (reg_wdata),
    .boundary   (boundary),
    .held_count (held_count),
    .ctrl       (ctrl),
    .flag       (flag),
    .rdata      (reg_rdata)
  );

  assign irq = flag & ctrl.irq_en;

  // Counting continues while synchronisation is lost.
  p_los_counts_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (los_ind && viol_event && !boundary && live_count != LCV_MAX)
      |=> (live_count == $past(live_count) + 1'b1));
  // A masked substitution-word violation adds nothing.
  p_sub_masked_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl.b8zs_en && b8zs_word && bpv_pulse && !exz_pulse && !boundary)
      |=> (live_count == $past(live_count)));
  // Two coincident event types add exactly one.
  p_merge_once_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (bpv_pulse && exz_pulse && !boundary && live_count != LCV_MAX)
      |=> (live_count == $past(live_count) + 1'b1));
endmodule

// File: tb/tb_lcv_perf_counter.sv
module tb_lcv_perf_counter;
  localparam int TPS = 70000;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       bpv = 0, exz = 0, sub = 0, los = 0, wr = 0;
  logic [7:0] addr = 8'h00, wdata = 8'h00;
  logic [7:0] rdata;
  logic       irq;

  int n_vec = 0, n_bad = 0;

  // bench model state
  int m_live = 0, m_hold = 0, m_tcnt = 0;
  bit m_selq = 0, m_flag = 0, m_bnd = 0;
  bit [2:0] m_ctrl = 3'b000;

  lcv_perf_counter #(.TICKS_PER_SEC(TPS)) dut (
    .clk(clk), .rst_n(rst_n), .bpv_pulse(bpv), .exz_pulse(exz),
    .b8zs_word(sub), .los_ind(los), .reg_addr(addr), .reg_wr(wr),
    .reg_wdata(wdata), .reg_rdata(rdata), .irq(irq)
  );

  always #4 clk = ~clk;

  function automatic int period_len(bit s);
    int whole = (TPS * 42) / 1000;
    int frac  = (TPS * 42) % 1000;
    if (!s) return TPS;
    return whole + ((frac >= 500) ? 1 : 0);
  endfunction

  function automatic int exp_read(logic [7:0] a);
    case (a)
      8'h20: return int'(m_ctrl);
      8'h21: return int'(m_flag);
      8'h23: return (m_hold >> 8) & 255;
      8'h24: return m_hold & 255;
      default: return 0;
    endcase
  endfunction

  function automatic bit counts(bit b, bit e, bit s);
    if (e) return 1;
    if (b && !(m_ctrl[2] && s)) return 1;
    return 0;
  endfunction

  task automatic check(string req, int act, int exp);
    n_vec++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h at %0t", req, act, exp, $time);
    end
  endtask

  // One clock: drive at negedge, compare current state, advance model.
  task automatic cycle(bit b, bit e, bit s, bit l, bit w, logic [7:0] a, logic [7:0] d);
    bit ev, bnd;
    bpv = b; exz = e; sub = s; los = l; wr = w; addr = a; wdata = d;
    #1;
    check((a == 8'h21) ? "R7 status" : ((a == 8'h23 || a == 8'h24) ? "R2/R12 result" : "R12 read"),
          int'(rdata), exp_read(a));
    check("R8 irq", int'(irq), int'(m_flag & m_ctrl[1]));
    ev  = counts(b, e, s);
    bnd = (m_ctrl[0] == m_selq) && (m_tcnt == period_len(m_selq) - 1);
    @(posedge clk);
    #1;
    m_bnd = bnd;
    if (m_ctrl[0] != m_selq || bnd) m_tcnt = 0; else m_tcnt++;
    m_selq = m_ctrl[0];
    if (bnd) begin m_hold = m_live; m_live = ev; end
    else if (m_live < 65535) m_live += ev;
    if (bnd) m_flag = 1;
    else if (w && a == 8'h21 && d[0]) m_flag = 0;
    if (w && a == 8'h20) m_ctrl = d[2:0];
    @(negedge clk);
  endtask

  task automatic idle(logic [7:0] a);
    cycle(0, 0, 0, 0, 0, a, 8'h00);
  endtask

  task automatic wait_boundary();
    m_bnd = 0;
    while (!m_bnd) idle(8'h21);
  endtask

  task automatic rand_cycle();
    bit b = ($urandom % 8) == 0;
    bit e = ($urandom % 16) == 0;
    bit s = ($urandom % 4) == 0;
    bit l = ($urandom % 4) == 0;
    int pick = $urandom % 5;
    logic [7:0] a = (pick == 0) ? 8'h20 : (pick == 1) ? 8'h21 :
                    (pick == 2) ? 8'h23 : (pick == 3) ? 8'h24 : 8'h30;
    int wr_pick = $urandom % 64;
    if (wr_pick == 0)      cycle(b, e, s, l, 1, 8'h21, 8'h01);
    else if (wr_pick == 1) cycle(b, e, s, l, 1, 8'h21, 8'h00);
    else if (wr_pick == 2) cycle(b, e, s, l, 1, 8'h20, {5'b0, 1'($urandom), 1'($urandom), 1'b1});
    else if (wr_pick == 3) cycle(b, e, s, l, 1, 8'h30, 8'($urandom));
    else                   cycle(b, e, s, l, 0, a, 8'h00);
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin : main
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset values
    check("R1 high", int'(dut.reg_rdata), int'(dut.reg_rdata)); // placeholder-free self compare avoided below
    n_vec--;
    idle(8'h23); check("R1 result high", int'(rdata), 0);
    idle(8'h24); check("R1 result low", int'(rdata), 0);
    idle(8'h20); check("R1 control", int'(rdata), 0);
    idle(8'h21); check("R1 status", int'(rdata), 0);
    check("R1 irq", int'(irq), 0);

    // short period, interrupt enabled
    cycle(0, 0, 0, 0, 1, 8'h20, 8'h03);
    wait_boundary();
    check("R5 short period boundary", m_tcnt, 0);

    // random traffic over several short intervals
    for (int i = 0; i < 9000; i++) rand_cycle();

    // R6: mid-interval period toggle restarts the timer
    cycle(0, 0, 0, 0, 1, 8'h20, 8'h02);
    for (int i = 0; i < 100; i++) idle(8'h21);
    cycle(0, 0, 0, 0, 1, 8'h20, 8'h03);
    begin
      int cyc = 0;
      m_bnd = 0;
      while (!m_bnd) begin idle(8'h21); cyc++; end
      check("R6 restart length", cyc, period_len(1'b1) + 1);
    end

    // R4: event in the boundary cycle lands in the next interval
    cycle(0, 0, 0, 0, 1, 8'h21, 8'h01);
    while (m_tcnt != period_len(1'b1) - 1) idle(8'h24);
    cycle(1, 0, 0, 0, 0, 8'h24, 8'h00);
    check("R4 boundary event excluded from old interval", m_hold, 0);
    wait_boundary();
    idle(8'h24); check("R4 boundary event counted once", int'(rdata), 1);
    idle(8'h23); check("R4 high byte", int'(rdata), 0);

    // R9/R10/R11 pattern with B8ZS masking on
    cycle(0, 0, 0, 0, 1, 8'h20, 8'h07);
    for (int i = 0; i < 10; i++) cycle(1, 0, 1, 0, 0, 8'h24, 8'h00); // R9 masked
    for (int i = 0; i < 5; i++)  cycle(0, 1, 1, 0, 0, 8'h24, 8'h00); // R9 exz kept
    for (int i = 0; i < 7; i++)  cycle(1, 1, 0, 0, 0, 8'h24, 8'h00); // R10 once
    for (int i = 0; i < 3; i++)  cycle(1, 0, 0, 1, 0, 8'h24, 8'h00); // R11 los
    cycle(0, 0, 0, 0, 1, 8'h20, 8'h03);
    for (int i = 0; i < 4; i++)  cycle(1, 0, 1, 0, 0, 8'h24, 8'h00); // R9 mask off
    wait_boundary();
    idle(8'h24); check("R9/R10/R11 pattern total", int'(rdata), 15 + 4);

    // R7: clear racing a boundary keeps the flag
    while (m_tcnt != period_len(1'b1) - 1) idle(8'h21);
    cycle(0, 0, 0, 0, 1, 8'h21, 8'h01);
    idle(8'h21); check("R7 boundary beats clear", int'(rdata), 1);
    cycle(0, 0, 0, 0, 1, 8'h20, 8'h01);
    idle(8'h21); check("R8 irq masked", int'(irq), 0);

    // R3: one-second interval flooded with events saturates
    cycle(0, 0, 0, 0, 1, 8'h20, 8'h02);
    m_bnd = 0;
    while (!m_bnd) cycle(1, 1, 0, 1, 0, 8'h21, 8'h00);
    m_bnd = 0;
    while (!m_bnd) cycle(1, 0, 0, 0, 0, 8'h24, 8'h00);
    idle(8'h23); check("R3 saturated high", int'(rdata), 8'hFF);
    idle(8'h24); check("R3 saturated low", int'(rdata), 8'hFF);
    check("R5 long period restart", m_tcnt, 2);

    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule